// File: doc/BRIEF.md
# Twelve-Line GPIO Port with Level Interrupts

This block is a general-purpose I/O port of twelve lines seen by software through eight 32-bit registers on a simple memory-mapped bus. For each line it holds an output value and a drive enable. It returns the line's synchronised input level. It also watches every line for an interrupt level whose polarity is set per line. When a line sits at its active level, its bit in a sticky status register is set. Software acknowledges a bit by writing a one to it. An enable mask selects which pending bits drive the single combined interrupt request.

Interrupts are level triggered only. If the source still holds the active level when software acknowledges it, the status bit reads zero for one cycle and then sets again. A handler therefore has to remove the cause before it acknowledges. Each line's polarity bit lives in one of two type registers at bit position 4*(n mod 8): lines 0 to 7 use the first register and lines 8 to 11 use the second. The pin-multiplexing control word is only stored.

Top module: `gpio_lvlirq_port`

## Requirements
- R1: After reset, every register reads 0, pin_oe is 0 and irq_out is 0.
- R2: Register 0x00 holds the output value and 0x04 the drive enable, one bit per line at bit n. pin_oe equals the enable bits, and pin_out[n] carries the output bit only when enable bit n is 1 (0 otherwise).
- R3: Register 0x08 returns the pin levels after a two-stage synchroniser. A pin change becomes readable after the second rising clock edge, and writes to 0x08 are ignored.
- R4: The polarity of line n is bit 4*(n mod 8) of register 0x10 (lines 0 to 7) or of register 0x18 (lines 8 to 11). All other bits of these two registers read 0 and ignore writes.
- R5: A polarity bit of 0 makes level 1 the active level, and a polarity bit of 1 makes level 0 active. Status bit n at 0x0C sets on the edge after the synchronised level of line n equals its active level.
- R6: A status bit stays set after its source goes inactive. Writing 1 to a bit of 0x0C clears it, and writing 0 leaves it unchanged.
- R7: If a line is still active when its status bit is cleared, the bit reads 0 for one cycle and sets again on the next clock edge.
- R8: Register 0x14 holds the interrupt enables (1 means unmasked). irq_out is 1 exactly when some line has both its status bit and its enable bit set. Status bits latch whether or not the line is enabled.
- R9: In registers 0x00, 0x04, 0x08, 0x0C and 0x14, bits 31:12 read 0 and ignore writes. Register 0x1C stores and returns all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; bits 4:2 pick the register, higher bits must be 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | 12 | Asynchronous pin levels |
| pin_out | output | 12 | Output level toward the pads |
| pin_oe | output | 12 | Per-line drive enable |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A table of pin patterns is applied, each paired with a polarity mask: all low, all high, alternating nibbles, and masks that mix both polarities within one pattern. Each result tells whether the active level is taken per line from the right bit of the right type register, or from a neighbouring line or the other group. Directed sequences then check that status survives the source going away. They also check that acknowledging while the source is present gives exactly one cycle of zero, and that enabling a line with a pending bit raises the request at once. A single polarity bit set for line 9 separates the two type registers.

// File: rtl/gpl_pkg.sv
package gpl_pkg;
   // register word index = byte address bits 4:2
   typedef enum logic [2:0] {
      W_DOUT = 3'd0,
      W_OE   = 3'd1,
      W_DIN  = 3'd2,
      W_STAT = 3'd3,
      W_POLA = 3'd4,
      W_IEN  = 3'd5,
      W_POLB = 3'd6,
      W_MUX  = 3'd7
   } gpl_word_e;

   localparam int GPL_GROUP_LINES = 8;
   localparam int GPL_POL_STRIDE  = 4;
   localparam int GPL_WORD_LSB    = 2;
   localparam int GPL_WORD_BITS   = 3;
endpackage

// File: rtl/gpl_sync.sv
module gpl_sync #(
   parameter int WIDTH  = 12,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= din;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpl_line_det.sv
module gpl_line_det (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic pol_we,
   input  logic pol_wbit,
   input  logic clr,
   output logic pol,
   output logic stat
);
   logic active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pol <= 1'b0;
      else if (pol_we) pol <= pol_wbit;
   end

   // 0 = active high, 1 = active low
   assign active = level ^ pol;

   // an acknowledge wins for one cycle; a live source sets the bit again next edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat <= 1'b0;
      else if (clr)    stat <= 1'b0;
      else if (active) stat <= 1'b1;
   end
endmodule

// File: rtl/gpio_lvlirq_port.sv
module gpio_lvlirq_port
   import gpl_pkg::*;
#(
   parameter int NUM_LINES   = 12,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NUM_LINES-1:0] pin_in,
   output logic [NUM_LINES-1:0] pin_out,
   output logic [NUM_LINES-1:0] pin_oe,
   output logic                 irq_out
);
   localparam int WORD_MSB = GPL_WORD_LSB + GPL_WORD_BITS - 1;
   localparam int MAX_LINES = 2 * GPL_GROUP_LINES;

   if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
      $error("NUM_LINES must be 1..%0d", MAX_LINES);
   end
   if (DATA_W != GPL_POL_STRIDE * GPL_GROUP_LINES) begin : g_bad_width
      $error("DATA_W must equal polarity stride times group size");
   end
   if (ADDR_W <= WORD_MSB + 1) begin : g_bad_addr
      $error("ADDR_W must exceed %0d", WORD_MSB + 1);
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_LINES-1:0] dout_q, oe_q, en_q, stat_q, pol_q, sync_q;
   logic [DATA_W-1:0]    mux_q;
   logic [DATA_W-1:0]    pol_rd_a, pol_rd_b;
   logic [DATA_W-1:0]    pol_spread [NUM_LINES];
   logic                 hit, wr_hit;
   gpl_word_e            word;

   assign hit    = bus_sel && (bus_addr[ADDR_W-1:WORD_MSB+1] == '0);
   assign wr_hit = hit && bus_wr;
   assign word   = gpl_word_e'(bus_addr[WORD_MSB:GPL_WORD_LSB]);

   gpl_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in),
      .dout (sync_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         oe_q   <= '0;
         en_q   <= '0;
         mux_q  <= '0;
      end else if (wr_hit) begin
         case (word)
            W_DOUT:  dout_q <= bus_wdata[NUM_LINES-1:0];
            W_OE:    oe_q   <= bus_wdata[NUM_LINES-1:0];
            W_IEN:   en_q   <= bus_wdata[NUM_LINES-1:0];
            W_MUX:   mux_q  <= bus_wdata;
            default: ;
         endcase
      end
   end

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      localparam gpl_word_e PW = (n < GPL_GROUP_LINES) ? W_POLA : W_POLB;
      localparam int        PB = GPL_POL_STRIDE * (n % GPL_GROUP_LINES);
      logic pol_n, stat_n;

      gpl_line_det u_det (
         .clk     (clk),
         .rst_n   (rst_n),
         .level   (sync_q[n]),
         .pol_we  (wr_hit && (word == PW)),
         .pol_wbit(bus_wdata[PB]),
         .clr     (wr_hit && (word == W_STAT) && bus_wdata[n]),
         .pol     (pol_n),
         .stat    (stat_n)
      );

      assign pol_q[n]      = pol_n;
      assign stat_q[n]     = stat_n;
      assign pol_spread[n] = DATA_W'(pol_n) << PB;
   end

   always_comb begin
      pol_rd_a = '0;
      pol_rd_b = '0;
      for (int n = 0; n < NUM_LINES; n++) begin
         if (n < GPL_GROUP_LINES) pol_rd_a = pol_rd_a | pol_spread[n];
         else                     pol_rd_b = pol_rd_b | pol_spread[n];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         case (word)
            W_DOUT: bus_rdata = DATA_W'(dout_q);
            W_OE:   bus_rdata = DATA_W'(oe_q);
            W_DIN:  bus_rdata = DATA_W'(sync_q);
            W_STAT: bus_rdata = DATA_W'(stat_q);
            W_POLA: bus_rdata = pol_rd_a;
            W_IEN:  bus_rdata = DATA_W'(en_q);
            W_POLB: bus_rdata = pol_rd_b;
            W_MUX:  bus_rdata = mux_q;
            default: bus_rdata = '0;
         endcase
      end
   end

   assign pin_oe  = oe_q;
   assign pin_out = dout_q & oe_q;
   assign irq_out = |(stat_q & en_q);
endmodule

// File: rtl/gpl_checker.sv
module gpl_checker #(
   parameter int NUM_LINES = 12,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_sel,
   input logic                 bus_wr,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [DATA_W-1:0]    bus_wdata,
   input logic [DATA_W-1:0]    bus_rdata,
   input logic                 irq_out,
   input logic [NUM_LINES-1:0] en_q,
   input logic [NUM_LINES-1:0] stat_q
);
   function automatic logic [DATA_W-1:0] grp_mask(input int g);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int n = 0; n < NUM_LINES; n++)
         if (n / 8 == g) m[4 * (n % 8)] = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] MASK_A = grp_mask(0);
   localparam logic [DATA_W-1:0] MASK_B = grp_mask(1);

   logic wr_stat, rd_narrow, rd_pola, rd_polb;
   assign wr_stat   = bus_sel && bus_wr && (bus_addr == ADDR_W'(8'h0C));
   assign rd_narrow = bus_sel && !bus_wr &&
                      (bus_addr == ADDR_W'(8'h00) || bus_addr == ADDR_W'(8'h04) ||
                       bus_addr == ADDR_W'(8'h08) || bus_addr == ADDR_W'(8'h0C) ||
                       bus_addr == ADDR_W'(8'h14));
   assign rd_pola   = bus_sel && !bus_wr && (bus_addr == ADDR_W'(8'h10));
   assign rd_polb   = bus_sel && !bus_wr && (bus_addr == ADDR_W'(8'h18));

   a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (en_q != '0));

   a_r6_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && (bus_wdata[NUM_LINES-1:0] == '1)) |=> (stat_q == '0));

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_sticky
      a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_q[i] && !(wr_stat && bus_wdata[i])) |=> stat_q[i]);
   end

   a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_narrow |-> (bus_rdata[DATA_W-1:NUM_LINES] == '0));

   a_r4_pola_unused: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pola |-> ((bus_rdata & ~MASK_A) == '0));

   a_r4_polb_unused: assert property (@(posedge clk) disable iff (!rst_n)
      rd_polb |-> ((bus_rdata & ~MASK_B) == '0));
endmodule

bind gpio_lvlirq_port gpl_checker #(
   .NUM_LINES(NUM_LINES),
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W)
) u_gpl_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .irq_out  (irq_out),
   .en_q     (en_q),
   .stat_q   (stat_q)
);

// File: tb/test_gpio_lvlirq_port.sv
module test_gpio_lvlirq_port;
   localparam logic [7:0] A_DOUT = 8'h00, A_OE = 8'h04, A_DIN = 8'h08, A_STAT = 8'h0C;
   localparam logic [7:0] A_POLA = 8'h10, A_IEN = 8'h14, A_POLB = 8'h18, A_MUX = 8'h1C;
   localparam int NVEC = 8;
   // {pins, polarity per line, expected status}
   localparam logic [35:0] VEC [NVEC] = '{
      {12'h000, 12'h000, 12'h000},
      {12'hFFF, 12'h000, 12'hFFF},
      {12'h000, 12'hFFF, 12'hFFF},
      {12'hA5C, 12'h000, 12'hA5C},
      {12'hA5C, 12'hFFF, 12'h5A3},
      {12'h0F0, 12'h00F, 12'h0FF},
      {12'h801, 12'h800, 12'h001},
      {12'h3C3, 12'h3C3, 12'h000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [11:0] pin_in = '0;
   logic [11:0] pin_out, pin_oe;
   logic        irq_out;
   int          n_checks = 0, n_errors = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   gpio_lvlirq_port i_gpio_lvlirq_port (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [31:0] spread(input logic [11:0] pol, input int g);
      logic [31:0] v;
      v = '0;
      for (int n = 0; n < 12; n++)
         if (n / 8 == g) v[4 * (n % 8)] = pol[n];
      return v;
   endfunction

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      step(2);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(8'(a * 4), d);
         check($sformatf("R1 reset reg %0h", a * 4), d, 32'h0);
      end
      check("R1 reset pin_oe", 32'(pin_oe), 32'h0);
      check("R1 reset irq_out", 32'(irq_out), 32'h0);

      // R5 table of pins and polarities, all lines enabled
      wr(A_IEN, 32'hFFF);
      for (int v = 0; v < NVEC; v++) begin
         pin_in = VEC[v][35:24];
         wr(A_POLA, spread(VEC[v][23:12], 0));
         wr(A_POLB, spread(VEC[v][23:12], 1));
         step(3);
         wr(A_STAT, 32'hFFF);
         step(1);
         rd(A_STAT, d);
         check($sformatf("R5 vector %0d status", v), d, 32'(VEC[v][11:0]));
         rd(A_DIN, d);
         check($sformatf("R3 vector %0d input", v), d, 32'(VEC[v][35:24]));
         check($sformatf("R8 vector %0d irq", v), 32'(irq_out), 32'(VEC[v][11:0] != 0));
      end

      // R4 polarity bit placement and unused bits
      wr(A_POLA, 32'hFFFF_FFFF);
      rd(A_POLA, d);
      check("R4 type reg A readback", d, 32'h1111_1111);
      wr(A_POLB, 32'hFFFF_FFFF);
      rd(A_POLB, d);
      check("R4 type reg B readback", d, 32'h0000_1111);
      pin_in = 12'h000;
      wr(A_POLA, 32'h0);
      wr(A_POLB, 32'h10);
      step(3);
      wr(A_STAT, 32'hFFF);
      step(1);
      rd(A_STAT, d);
      check("R4 line 9 low-active only", d, 32'h200);
      wr(A_POLB, 32'h0);

      // R3 synchroniser latency
      pin_in = 12'h000;
      step(3);
      wr(A_DIN, 32'hFFF);
      pin_in = 12'h5A5;
      @(posedge clk); @(negedge clk);
      rd(A_DIN, d);
      check("R3 input after one edge", d, 32'h000);
      @(posedge clk); @(negedge clk);
      rd(A_DIN, d);
      check("R3 input after two edges", d, 32'h5A5);

      // R6 sticky status and write-one-to-clear
      pin_in = 12'h000;
      step(3);
      wr(A_STAT, 32'hFFF);
      pin_in = 12'h00F;
      step(3);
      pin_in = 12'h000;
      step(3);
      rd(A_STAT, d);
      check("R6 status held after source gone", d, 32'h00F);
      wr(A_STAT, 32'h005);
      rd(A_STAT, d);
      check("R6 ones clear selected bits", d, 32'h00A);
      wr(A_STAT, 32'h000);
      rd(A_STAT, d);
      check("R6 zeros leave status", d, 32'h00A);

      // R7 acknowledge while source still active
      pin_in = 12'h001;
      step(3);
      wr(A_STAT, 32'h001);
      rd(A_STAT, d);
      check("R7 cleared for one cycle", d, 32'h00A);
      step(1);
      rd(A_STAT, d);
      check("R7 set again next edge", d, 32'h00B);

      // R8 latching regardless of enable, immediate request on enable
      wr(A_IEN, 32'h0);
      pin_in = 12'h000;
      step(3);
      wr(A_STAT, 32'hFFF);
      pin_in = 12'h100;
      step(3);
      rd(A_STAT, d);
      check("R8 latched while disabled", d, 32'h100);
      check("R8 irq low while masked", 32'(irq_out), 32'h0);
      wr(A_IEN, 32'h100);
      rd(A_STAT, d);
      check("R8 irq on enable of pending line", 32'(irq_out), 32'h1);
      wr(A_IEN, 32'hFFFF_F0FF);
      check("R8 irq low with other lines only", 32'(irq_out), 32'h0);
      rd(A_IEN, d);
      check("R9 enable upper bits ignored", d, 32'h0FF);

      // R2 output drive
      wr(A_DOUT, 32'hFFFF_FABC);
      rd(A_DOUT, d);
      check("R9 output data upper bits", d, 32'h0000_0ABC);
      wr(A_OE, 32'h0);
      check("R2 no drive when disabled", 32'(pin_out), 32'h000);
      wr(A_OE, 32'h0F0);
      check("R2 pin_oe follows enable", 32'(pin_oe), 32'h0F0);
      check("R2 pin_out masked by enable", 32'(pin_out), 32'h0B0);

      // R9 mux storage
      wr(A_MUX, 32'hDEAD_BEEF);
      rd(A_MUX, d);
      check("R9 mux word stored", d, 32'hDEAD_BEEF);

      finish_run();
   end
endmodule